// File: doc/BRIEF.md
# Text Console Screen Writer

This block takes a stream of byte-wide characters over a valid/ready handshake and places each one into a character-mapped screen memory. It has a single synchronous write port made of an address, a data byte and a write strobe. The next screen location is kept in a 16-bit write pointer. After reset the pointer starts at a fixed base address, and every store moves it on by one location.

Printable bytes reach memory unchanged. A control byte, meaning any value below the printable threshold, is replaced by a placeholder glyph before it is stored. Because of this, stray control traffic shows up on screen as a visible mark and is not acted on. A synchronous load input can move the pointer to any address, so the caller can place text anywhere in the 64 KiB space. Past 0xFFFF the pointer silently wraps to 0x0000.

Top module: `text_screen_writer`

## Requirements
- R1: After reset, `mem_we` is low and `in_ready` is high. The first character accepted with no pointer load in between is written to address 0x7C00.
- R2: An accepted byte whose value is below 32 is written as the value 42 (ASCII '*').
- R3: An accepted byte whose value is 32 or above is written unchanged.
- R4: A character accepted in clock cycle t (`in_valid` and `in_ready` both high at the rising edge) appears in cycle t+1 as `mem_we` = 1, with `mem_addr` equal to the pointer value held at acceptance and no offset added.
- R5: Each store moves the pointer forward by one. The low byte steps first, and the high byte steps only when the low byte rolls over from 0xFF to 0x00 (for example, 0x7CFF is followed by 0x7D00).
- R6: A store at address 0xFFFF is followed by a store at 0x0000, with no other indication.
- R7: While `load_en` is high, `in_ready` is low and no character is accepted. The pointer takes `load_addr` at that edge, so the next store goes to that address.
- R8: In a cycle with no acceptance, `mem_we` is low in the following cycle and the pointer keeps its value.
- R9: With `load_en` low, `in_ready` is high, and characters presented on consecutive cycles are stored on consecutive cycles at consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character present on `in_data` |
| in_data | input | 8 | Incoming character byte |
| in_ready | output | 1 | Block can take a character this cycle |
| load_en | input | 1 | Load the write pointer from `load_addr` |
| load_addr | input | 16 | New write pointer value |
| mem_we | output | 1 | Screen memory write strobe, one cycle per character |
| mem_addr | output | 16 | Screen memory write address |
| mem_wdata | output | 8 | Screen memory write data |

## Verification
The bench uses the default parameters: base address 0x7C00, threshold 32 and placeholder 42. These settings put the reset base directly in the first store. Loading 0x7CFF and 0xFFFF through the load port reaches the low-byte carry and the full wrap within a couple of writes. Random streams mix control and printable bytes with idle cycles and loads, so the threshold edge at 31 and 32 and back-to-back runs are covered too.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
    localparam int CHAR_W = 8;
    localparam int PTR_W  = 16;

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    // complete registered state of the writer
    typedef struct packed {
        ptr_t  ptr;
        logic  we;
        ptr_t  addr;
        char_t wdata;
    } wr_state_t;
endpackage

// File: rtl/tsw_glyph_filter.sv
module tsw_glyph_filter #(
    parameter int          W       = 8,
    parameter int          MIN_PR  = 32,
    parameter logic [W-1:0] GLYPH  = 42
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] shown
);
    localparam logic [W-1:0] THRESH = W'(MIN_PR);

    always_comb begin
        if (raw < THRESH) shown = GLYPH;
        else              shown = raw;
    end
endmodule

// File: rtl/tsw_ptr_step.sv
module tsw_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam int LO_W = W / 2;
    localparam int HI_W = W - LO_W;

    generate
        if (W >= 2) begin : g_split
            logic [LO_W-1:0] lo_nxt;
            logic            lo_carry;
            logic [HI_W-1:0] hi_nxt;
            always_comb begin
                {lo_carry, lo_nxt} = {1'b0, cur[LO_W-1:0]} + {{LO_W{1'b0}}, 1'b1};
                hi_nxt = cur[W-1:LO_W] + {{(HI_W-1){1'b0}}, lo_carry};
                nxt    = {hi_nxt, lo_nxt};
            end
        end else begin : g_flat
            always_comb nxt = cur + 1'b1;
        end
    endgenerate
endmodule

// File: rtl/text_screen_writer.sv
module text_screen_writer
    import tsw_pkg::*;
#(
    parameter logic [PTR_W-1:0]  BASE_ADDR = 16'h7C00,
    parameter int                PRINT_MIN = 32,
    parameter logic [CHAR_W-1:0] GLYPH     = 8'd42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    output logic              in_ready,
    input  logic              load_en,
    input  logic [PTR_W-1:0]  load_addr,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [CHAR_W-1:0] mem_wdata
);
    wr_state_t st_d, st_q;
    char_t     shown;
    ptr_t      ptr_inc;
    logic      accept;

    tsw_glyph_filter #(
        .W      (CHAR_W),
        .MIN_PR (PRINT_MIN),
        .GLYPH  (GLYPH)
    ) u_filter (
        .raw   (in_data),
        .shown (shown)
    );

    tsw_ptr_step #(.W(PTR_W)) u_step (
        .cur (st_q.ptr),
        .nxt (ptr_inc)
    );

    always_comb begin
        in_ready = !load_en;
        accept   = in_valid && in_ready;
        st_d     = st_q;
        st_d.we  = accept;
        if (accept) begin
            st_d.addr  = st_q.ptr;
            st_d.wdata = shown;
            st_d.ptr   = ptr_inc;
        end
        if (load_en) st_d.ptr = load_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr   <= BASE_ADDR;
            st_q.we    <= 1'b0;
            st_q.addr  <= '0;
            st_q.wdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
    parameter logic [15:0] BASE_ADDR = 16'h7C00,
    parameter int          PRINT_MIN = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  in_data,
    input logic        in_ready,
    input logic        load_en,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata
);
    logic        first_q;
    logic        prev_ok_q;
    logic [15:0] prev_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q     <= 1'b1;
            prev_ok_q   <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            if (mem_we) begin
                first_q     <= 1'b0;
                prev_ok_q   <= 1'b1;
                prev_addr_q <= mem_addr;
            end
            if (load_en) begin
                first_q   <= 1'b0;
                prev_ok_q <= 1'b0;
            end
        end
    end

    // R1
    first_store_at_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && first_q) |-> (mem_addr == BASE_ADDR));

    // R2
    ctrl_replaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata >= 8'(PRINT_MIN)));

    // R3
    printable_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data >= 8'(PRINT_MIN)) |=> (mem_wdata == $past(in_data)));

    // R4
    accept_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> mem_we);

    // R5
    pointer_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && prev_ok_q) |-> (mem_addr == prev_addr_q + 16'd1));

    // R7
    load_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !in_ready);

    // R8
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !mem_we);
endmodule

bind text_screen_writer tsw_checker #(
    .BASE_ADDR (BASE_ADDR),
    .PRINT_MIN (PRINT_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .load_en   (load_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/test_text_screen_writer.sv
module test_text_screen_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        load_en = 1'b0;
    logic [15:0] load_addr = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_ptr = 16'h7C00;

    always #5 clk = ~clk;

    text_screen_writer i_text_screen_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .load_en(load_en), .load_addr(load_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [7:0] exp_glyph(input logic [7:0] d);
        return (d < 8'd32) ? 8'd42 : d;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // one cycle: drive at negedge, check registered outputs after the next posedge
    task automatic step(input bit v, input logic [7:0] d, input bit l,
                        input logic [15:0] la, input string atag);
        bit          acc;
        logic [15:0] a_exp;
        @(negedge clk);
        in_valid = v; in_data = d; load_en = l; load_addr = la;
        #1;
        check(in_ready == !l, l ? "R7 ready" : "R9 ready", {31'd0, in_ready}, {31'd0, !l});
        acc   = v && !l;
        a_exp = exp_ptr;
        if (l)        exp_ptr = la;
        else if (acc) exp_ptr = exp_ptr + 16'd1;
        @(posedge clk);
        #1;
        check(mem_we == acc, acc ? "R4 we" : (l ? "R7 we" : "R8 we"),
              {31'd0, mem_we}, {31'd0, acc});
        if (acc) begin
            check(mem_addr == a_exp, atag, {16'd0, mem_addr}, {16'd0, a_exp});
            check(mem_wdata == exp_glyph(d), (d < 8'd32) ? "R2 data" : "R3 data",
                  {24'd0, mem_wdata}, {24'd0, exp_glyph(d)});
        end
    endtask

    initial begin
        #1_000_000;
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(mem_we == 1'b0, "R1 we", {31'd0, mem_we}, 0);
        check(in_ready == 1'b1, "R1 ready", {31'd0, in_ready}, 1);
        step(1, 8'h41, 0, 0, "R1 addr");
        step(1, 8'h1F, 0, 0, "R5 addr");   // threshold-1 -> glyph
        step(1, 8'h20, 0, 0, "R9 addr");   // threshold kept
        step(1, 8'h00, 0, 0, "R9 addr");
        step(0, 8'h55, 0, 0, "R8 addr");   // idle
        step(0, 8'h55, 0, 0, "R8 addr");
        step(1, 8'h7E, 0, 0, "R8 addr");   // pointer held through idle
        // R5 low-byte carry
        step(1, 8'h33, 1, 16'h7CFF, "R7 addr");
        step(1, 8'h61, 0, 0, "R7 addr");
        step(1, 8'h62, 0, 0, "R5 addr");
        // R6 full wrap
        step(0, 8'h00, 1, 16'hFFFF, "R7 addr");
        step(1, 8'h0A, 0, 0, "R6 addr");
        step(1, 8'hFF, 0, 0, "R6 addr");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[3:0] != 0, r[15:8], r[7:4] == 0, r[31:16], "R5 addr");
        end
        step(0, 8'h00, 0, 0, "R8 addr");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule